// File: doc/BRIEF.md
# System Control Register Block

A small memory-mapped control block on a 32-bit APB-style bus (select, enable, write, ready, error). It occupies a 4 KiB address window, of which only three registers are live: two read-only identification words (processor version and system version) that arrive on input ports, and a write-only reset-control register. Setting its trigger bit issues a one-cycle system reset request.

Every other offset in the window reads as zero and ignores writes. Any access to an offset that is not live for its direction raises a one-cycle diagnostic pulse. Only full-word accesses are legal. Any other size completes with an error response and has no side effect. Register words appear on the bus in big-endian byte order: the register's most significant byte travels in the lowest data lane.

Top module: `scr_block`

## Requirements
- R1: The register offset is the bus address modulo 0x1000, so the upper address bits are ignored and every 4 KiB alias reaches the same registers.
- R2: A word read at offset 0xA0 returns `cpu_ver`, sampled in the access phase, with bytes reversed on the bus: `prdata[7:0]` holds `cpu_ver[31:24]`, and so on through `prdata[31:24]`, which holds `cpu_ver[7:0]`.
- R3: A word read at offset 0xA4 returns `sys_ver`, sampled in the access phase and byte-reversed in the same way as R2.
- R4: A word write at offset 0xB0 whose register bit 1 is set (bus bit `pwdata[25]` after byte reversal) makes `sys_reset_req` high for exactly the one cycle after the access phase. All other data bits are ignored.
- R5: A word write at offset 0xB0 with register bit 1 clear produces no reset request. This holds even when `pwdata[1]` is set.
- R6: A word read of any offset other than 0xA0 and 0xA4 returns zero, and `unmapped_hit` is high for the one cycle after the access phase. This includes 0xB0. Outside a read access phase `prdata` is zero.
- R7: A word write to any offset other than 0xB0 produces no reset request, and `unmapped_hit` is high for the one cycle after the access phase.
- R8: `psize` encodes the access size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). Any size other than 2 sets `pslverr` in the access phase, returns zero read data, and produces neither a reset request nor a diagnostic pulse.
- R9: `pready` is high in every access phase, so there are no wait states. `pslverr` is low for word accesses.
- R10: While `rst` is high and after it is released, `sys_reset_req` and `unmapped_hit` are low until an access causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Byte address |
| psize | input | 2 | Access size code (log2 of bytes) |
| pwdata | input | 32 | Write data, big-endian lanes |
| prdata | output | 32 | Read data, big-endian lanes |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Illegal access size |
| cpu_ver | input | 32 | Processor version word |
| sys_ver | input | 32 | System version word |
| sys_reset_req | output | 1 | One-cycle system reset request |
| unmapped_hit | output | 1 | One-cycle unknown-offset diagnostic |

## Verification
The bench sweeps every word offset of the window for both reads and writes, and repeats some of them through a high address alias. A design that decoded too few address bits would then show live registers at extra offsets, and one that decoded too many would miss the alias. Writes to the reset register place the trigger bit in the wrong lane (`pwdata[1]`) as well as the right one (`pwdata[25]`), which exposes a missing or doubled byte swap. Reads of 0xB0 and writes to the identification offsets must flag the diagnostic, which catches a decoder that ignores direction. Every non-word size is tried on the live offsets to show that an erroring access still firing a reset or a diagnostic would be caught. Pulse widths are checked one cycle later to catch a level instead of a pulse.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned WIN_BYTES   = 4096;
    localparam int unsigned OFF_W       = $clog2(WIN_BYTES);
    localparam int unsigned SIZE_W      = 2;
    localparam int unsigned BYTES_PER_W = DATA_W / 8;

    localparam logic [SIZE_W-1:0] WORD_SIZE = SIZE_W'($clog2(BYTES_PER_W));

    localparam logic [OFF_W-1:0] OFF_CPU_VER = OFF_W'(12'h0A0);
    localparam logic [OFF_W-1:0] OFF_SYS_VER = OFF_W'(12'h0A4);
    localparam logic [OFF_W-1:0] OFF_RST_CTL = OFF_W'(12'h0B0);

    localparam int unsigned RST_TRIG_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_CPU_VER = 2'd1,
        SEL_SYS_VER = 2'd2,
        SEL_RST_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             active;
        logic             write;
        logic             size_ok;
        logic [OFF_W-1:0] offset;
    } access_t;

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < int'(BYTES_PER_W); i++) begin
            r[i*8 +: 8] = w[(int'(BYTES_PER_W)-1-i)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic trigger_bit(input logic [DATA_W-1:0] reg_word);
        return reg_word[RST_TRIG_BIT];
    endfunction

endpackage

// File: rtl/scr_access_qual.sv
module scr_access_qual
    import scr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [SIZE_W-1:0] psize,
    output access_t           acc
);
    always_comb begin
        acc.active  = psel && penable;
        acc.write   = pwrite;
        acc.size_ok = (psize == WORD_SIZE);
        acc.offset  = OFF_W'(paddr % ADDR_W'(WIN_BYTES));
    end
endmodule

// File: rtl/scr_addr_decode.sv
module scr_addr_decode
    import scr_pkg::*;
(
    input  access_t  acc,
    output reg_sel_e sel,
    output logic     unknown
);
    always_comb begin
        sel = SEL_NONE;
        unique case (acc.offset)
            OFF_CPU_VER: sel = SEL_CPU_VER;
            OFF_SYS_VER: sel = SEL_SYS_VER;
            OFF_RST_CTL: sel = SEL_RST_CTL;
            default:     sel = SEL_NONE;
        endcase
        if (acc.write) begin
            unknown = (sel != SEL_RST_CTL);
        end else begin
            unknown = (sel != SEL_CPU_VER) && (sel != SEL_SYS_VER);
        end
    end
endmodule

// File: rtl/scr_lane_order.sv
module scr_lane_order
    import scr_pkg::*;
#(
    parameter bit BIG_ENDIAN_BUS = 1'b1
) (
    input  logic [DATA_W-1:0] reg_in,
    output logic [DATA_W-1:0] bus_out,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] reg_out
);
    generate
        if (BIG_ENDIAN_BUS) begin : g_swap
            assign bus_out = swap_bytes(reg_in);
            assign reg_out = swap_bytes(bus_in);
        end else begin : g_pass
            assign bus_out = reg_in;
            assign reg_out = bus_in;
        end
    endgenerate
endmodule

// File: rtl/scr_block.sv
module scr_block
    import scr_pkg::*;
#(
    parameter int unsigned ADDR_W         = 32,
    parameter bit          BIG_ENDIAN_BUS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [SIZE_W-1:0] psize,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [DATA_W-1:0] cpu_ver,
    input  logic [DATA_W-1:0] sys_ver,
    output logic              sys_reset_req,
    output logic              unmapped_hit
);
    access_t           acc;
    reg_sel_e          sel;
    logic              unknown;
    logic [DATA_W-1:0] rd_reg;
    logic [DATA_W-1:0] rd_bus;
    logic [DATA_W-1:0] wr_reg;
    logic              good_acc;
    logic              rst_req_q;
    logic              unm_q;

    scr_access_qual #(.ADDR_W(ADDR_W)) qual_i (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .psize   (psize),
        .acc     (acc)
    );

    scr_addr_decode dec_i (
        .acc     (acc),
        .sel     (sel),
        .unknown (unknown)
    );

    scr_lane_order #(.BIG_ENDIAN_BUS(BIG_ENDIAN_BUS)) lanes_i (
        .reg_in  (rd_reg),
        .bus_out (rd_bus),
        .bus_in  (pwdata),
        .reg_out (wr_reg)
    );

    assign good_acc = acc.active && acc.size_ok;

    always_comb begin
        rd_reg = '0;
        if (good_acc && !acc.write) begin
            case (sel)
                SEL_CPU_VER: rd_reg = cpu_ver;
                SEL_SYS_VER: rd_reg = sys_ver;
                default:     rd_reg = '0;
            endcase
        end
    end

    assign prdata  = rd_bus;
    assign pready  = acc.active;
    assign pslverr = acc.active && !acc.size_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q <= 1'b0;
            unm_q     <= 1'b0;
        end else begin
            rst_req_q <= good_acc && acc.write && (sel == SEL_RST_CTL)
                         && trigger_bit(wr_reg);
            unm_q     <= good_acc && unknown;
        end
    end

    assign sys_reset_req = rst_req_q;
    assign unmapped_hit  = unm_q;

endmodule

// File: rtl/scr_block_chk.sv
module scr_block_chk
    import scr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [SIZE_W-1:0] psize,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              sys_reset_req,
    input logic              unmapped_hit
);
    // R9
    ready_in_access_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable) |-> pready);

    // R8
    size_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && psize != WORD_SIZE) |=> (!sys_reset_req && !unmapped_hit));

    // R4
    reset_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |=> !sys_reset_req);

    // R4
    reset_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> $past(psel && penable && pwrite && !pslverr));

    // R6
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable && !pwrite) |-> (prdata == '0));

    // R7
    unmapped_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        unmapped_hit |-> $past(psel && penable && !pslverr));
endmodule

bind scr_block scr_block_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .psel          (psel),
    .penable       (penable),
    .pwrite        (pwrite),
    .psize         (psize),
    .prdata        (prdata),
    .pready        (pready),
    .pslverr       (pslverr),
    .sys_reset_req (sys_reset_req),
    .unmapped_hit  (unmapped_hit)
);

// File: tb/scr_block_tb.sv
module scr_block_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [31:0] paddr, pwdata, cpu_ver, sys_ver;
    logic [1:0]  psize;
    logic [31:0] prdata;
    logic        pready, pslverr, sys_reset_req, unmapped_hit;

    int checks = 0;
    int errors = 0;

    logic [31:0] s_rdata;
    logic        s_ready, s_err, s_rst1, s_unm1, s_rst2, s_unm2;

    always #4 clk = ~clk;

    scr_block dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .psize(psize), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .cpu_ver(cpu_ver), .sys_ver(sys_ver),
        .sys_reset_req(sys_reset_req), .unmapped_hit(unmapped_hit)
    );

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; psize = sz; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        s_rdata = prdata; s_ready = pready; s_err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
        s_rst1 = sys_reset_req; s_unm1 = unmapped_hit;
        @(negedge clk);
        #1;
        s_rst2 = sys_reset_req; s_unm2 = unmapped_hit;
    endtask

    task automatic expect_all(input string req, input logic [31:0] er, input logic ee,
                              input logic erst, input logic eunm);
        chk(req, "prdata", s_rdata, er);
        chk("R9", "pready", 32'(s_ready), 32'd1);
        chk(req, "pslverr", 32'(s_err), 32'(ee));
        chk(req, "reset pulse", 32'(s_rst1), 32'(erst));
        chk(req, "unmapped pulse", 32'(s_unm1), 32'(eunm));
        chk(req, "reset pulse end", 32'(s_rst2), 32'd0);
        chk(req, "unmapped pulse end", 32'(s_unm2), 32'd0);
    endtask

    initial begin : watchdog
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = 0; psize = 2;
        pwdata = 0; cpu_ver = 32'h8021_0030; sys_ver = 32'h8039_0121;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset req in reset", 32'(sys_reset_req), 32'd0);
        chk("R10", "unmapped in reset", 32'(unmapped_hit), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset req after reset", 32'(sys_reset_req), 32'd0);
        chk("R10", "unmapped after reset", 32'(unmapped_hit), 32'd0);
        chk("R6", "idle prdata", prdata, 32'd0);

        // R2 R3 R6 full read sweep of the window
        for (int off = 0; off < 4096; off += 4) begin
            logic [31:0] exp_d;
            logic        live;
            cpu_ver = 32'hC0DE_0000 | 32'(off);
            sys_ver = 32'h5EED_0000 ^ 32'(off << 4);
            live  = (off == 'hA0) || (off == 'hA4);
            exp_d = (off == 'hA0) ? rev(cpu_ver) : (off == 'hA4) ? rev(sys_ver) : 32'd0;
            xfer(1'b0, 32'(off), 2'd2, 32'd0);
            expect_all(live ? ((off == 'hA0) ? "R2" : "R3") : "R6", exp_d, 1'b0, 1'b0, !live);
        end

        // R7 R4 full write sweep with all data bits set
        for (int off = 0; off < 4096; off += 4) begin
            xfer(1'b1, 32'(off), 2'd2, 32'hFFFF_FFFF);
            expect_all((off == 'hB0) ? "R4" : "R7", 32'd0, 1'b0, off == 'hB0, off != 'hB0);
        end

        // R1 aliases through upper address bits
        cpu_ver = 32'h1122_3344; sys_ver = 32'hA1B2_C3D4;
        xfer(1'b0, 32'h0005_30A0, 2'd2, 32'd0);
        expect_all("R1", 32'h4433_2211, 1'b0, 1'b0, 1'b0);
        xfer(1'b0, 32'hFFFF_F0A4, 2'd2, 32'd0);
        expect_all("R1", 32'hD4C3_B2A1, 1'b0, 1'b0, 1'b0);
        xfer(1'b1, 32'h8000_10B0, 2'd2, 32'h0200_0000);
        expect_all("R1", 32'd0, 1'b0, 1'b1, 1'b0);
        xfer(1'b0, 32'h0000_10A8, 2'd2, 32'd0);
        expect_all("R1", 32'd0, 1'b0, 1'b0, 1'b1);

        // R4 trigger only bit in lane 3
        xfer(1'b1, 32'h0000_00B0, 2'd2, 32'h0200_0000);
        expect_all("R4", 32'd0, 1'b0, 1'b1, 1'b0);
        // R5 trigger bit clear, other bits set
        xfer(1'b1, 32'h0000_00B0, 2'd2, 32'h0000_0002);
        expect_all("R5", 32'd0, 1'b0, 1'b0, 1'b0);
        xfer(1'b1, 32'h0000_00B0, 2'd2, 32'hFDFF_FFFF);
        expect_all("R5", 32'd0, 1'b0, 1'b0, 1'b0);
        xfer(1'b1, 32'h0000_00B0, 2'd2, 32'h0000_0000);
        expect_all("R5", 32'd0, 1'b0, 1'b0, 1'b0);

        // R8 every illegal size on live and dead offsets
        for (int sz = 0; sz < 4; sz++) begin
            if (sz == 2) continue;
            xfer(1'b0, 32'h0000_00A0, 2'(sz), 32'd0);
            expect_all("R8", 32'd0, 1'b1, 1'b0, 1'b0);
            xfer(1'b0, 32'h0000_00A4, 2'(sz), 32'd0);
            expect_all("R8", 32'd0, 1'b1, 1'b0, 1'b0);
            xfer(1'b1, 32'h0000_00B0, 2'(sz), 32'hFFFF_FFFF);
            expect_all("R8", 32'd0, 1'b1, 1'b0, 1'b0);
            xfer(1'b1, 32'h0000_0100, 2'(sz), 32'hFFFF_FFFF);
            expect_all("R8", 32'd0, 1'b1, 1'b0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule